// File: doc/BRIEF.md
# Critical-Path Replica Voltage Servo

This block closes a supply-voltage loop around a replica of a chip's slowest timing path. In every measurement it sends a rising edge into a trimmable delay chain, then latches a row of taps spread along that chain at the end of the next cycle. The latched word shows how many stages the edge crossed in one clock period. The block converts that word to a stage count and compares the count with a programmed target stage plus a programmed safety margin. If the edge falls short, the block asks an external regulator for one code step up. If the edge overshoots by more than a hysteresis band, it asks for one step down. Otherwise the voltage is held.

A single step request is outstanding at any time. After the regulator acknowledges a step, the block waits a fixed number of cycles for the supply to settle before it measures again. The chain's output tap is chosen by a trim value that is written once at manufacturing test and then locks. Software can read the last valid stage count and a sticky flag that marks a malformed tap word.

Top module: `replicaServo`

## Requirements
- R1: A measurement drives `launch` high for exactly one cycle and `sample` high for exactly the following cycle. The tap word present during the `sample` cycle is latched at the end of that cycle.
- R2: Bit i of `tapVec` reads 1 when the edge has passed stage i+1. For a valid word, the edge position is the number of ones. It appears on `edgePos` two cycles after the `sample` cycle.
- R3: A word whose ones are not contiguous from bit 0 sets `bubbleErr`, which then stays set until reset. That sample is ignored: no request is made, and neither `vCode` nor `edgePos` changes.
- R4: If the position is below `cfgTarget + cfgMargin`, the block requests a raise (`vReq` = 1, `vUp` = 1).
- R5: If the position is above `cfgTarget + cfgMargin + cfgHyst`, the block requests a lower (`vReq` = 1, `vUp` = 0). A position between these limits, inclusive, gives no request.
- R6: `vReq` and `vUp` hold steady until `vAck`. In the acknowledge cycle `vCode` moves by exactly one in the requested direction. `vCode` changes at no other time.
- R7: After an acknowledge, the next `launch` comes exactly `SETTLE_CYC` + 1 cycles after the acknowledge cycle.
- R8: A raise is suppressed when `vCode` equals `cfgMaxCode`, and a lower is suppressed when `vCode` equals `cfgMinCode`. A suppressed decision acts as a hold.
- R9: The first `trimWe` pulse after reset loads `tapSel`. Every later write is ignored.
- R10: In reset, `vCode` equals `CODE_INIT`, and `vReq`, `launch`, `sample`, `bubbleErr` and `edgePos` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Runs measurements while high |
| trimWe | input | 1 | Trim write strobe (takes effect once) |
| trimVal | input | SEL_W | Trim value to load |
| tapSel | output | SEL_W | Locked chain output-tap select |
| cfgTarget | input | PW | Target stage |
| cfgMargin | input | PW | Extra margin in stages |
| cfgHyst | input | PW | Hysteresis band in stages |
| cfgMinCode | input | CODE_W | Lowest voltage code |
| cfgMaxCode | input | CODE_W | Highest voltage code |
| launch | output | 1 | Edge launch strobe |
| sample | output | 1 | Tap capture strobe |
| tapVec | input | TAPS | Captured chain taps |
| vReq | output | 1 | Step request |
| vUp | output | 1 | Step direction, 1 = raise |
| vAck | input | 1 | Regulator acknowledge |
| vCode | output | CODE_W | Current voltage code |
| edgePos | output | PW | Last valid edge position |
| bubbleErr | output | 1 | Sticky malformed-word flag |

## Verification
A wrong internal state shows at the ports within one measurement, which is at most about `SETTLE_CYC` + 5 cycles. A bad threshold sum or limit compare shows up two cycles after `sample`, as the wrong `vReq`/`vUp` pair. A corrupted code register or step direction shows as a `vCode` at the next `launch` that differs from the step-by-step model. A settle counter loaded with the wrong value moves `launch` relative to the acknowledge. A broken bubble detector either fails to raise `bubbleErr` or lets a malformed word through, which then changes `edgePos` or issues a request.

// File: rtl/servoPkg.sv
package servoPkg;
  typedef enum logic [2:0] {
    S_IDLE, S_LAUNCH, S_SAMPLE, S_EVAL, S_REQ, S_SETTLE
  } servoState_t;

  // Control -> datapath strobes
  typedef struct packed {
    logic capture;
    logic eval;
    logic step;
  } servoStrobe_t;

  // Datapath -> control flags
  typedef struct packed {
    logic wantUp;
    logic wantDown;
    logic settleDone;
  } servoFlags_t;
endpackage

// File: rtl/tapDecode.sv
module tapDecode #(
  parameter int N  = 16,
  parameter int PW = 5
) (
  input  logic [N-1:0]  word,
  output logic [PW-1:0] pos,
  output logic          valid
);
  logic [N-2:0] holeBits;

  // A hole is a one sitting above a zero: not a thermometer code.
  for (genvar i = 0; i < N - 1; i++) begin : gHole
    assign holeBits[i] = word[i+1] & ~word[i];
  end

  assign valid = ~|holeBits;

  always_comb begin
    pos = '0;
    for (int i = 0; i < N; i++) pos = pos + PW'(word[i]);
  end
endmodule

// File: rtl/servoControl.sv
module servoControl
  import servoPkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         enable,
  input  logic         vAck,
  input  servoFlags_t  flags,
  output servoStrobe_t strobe,
  output logic         launch,
  output logic         sample,
  output logic         vReq
);
  servoState_t state, nextState;

  always_comb begin
    nextState = state;
    unique case (state)
      S_IDLE:   if (enable) nextState = S_LAUNCH;
      S_LAUNCH: nextState = S_SAMPLE;
      S_SAMPLE: nextState = S_EVAL;
      S_EVAL:
        if (flags.wantUp || flags.wantDown) nextState = S_REQ;
        else nextState = enable ? S_LAUNCH : S_IDLE;
      S_REQ:    if (vAck) nextState = S_SETTLE;
      S_SETTLE:
        if (flags.settleDone) nextState = enable ? S_LAUNCH : S_IDLE;
      default:  nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nextState;
  end

  assign launch         = (state == S_LAUNCH);
  assign sample         = (state == S_SAMPLE);
  assign vReq           = (state == S_REQ);
  assign strobe.capture = (state == S_SAMPLE);
  assign strobe.eval    = (state == S_EVAL);
  assign strobe.step    = (state == S_REQ) && vAck;
endmodule

// File: rtl/servoDatapath.sv
module servoDatapath
  import servoPkg::*;
#(
  parameter int TAPS       = 16,
  parameter int CODE_W     = 6,
  parameter int SEL_W      = 3,
  parameter int SETTLE_CYC = 4,
  parameter int CODE_INIT  = 8,
  localparam int PW        = $clog2(TAPS + 1),
  localparam int XW        = PW + 2,
  localparam int STW       = $clog2(SETTLE_CYC + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  servoStrobe_t      strobe,
  output servoFlags_t       flags,
  input  logic              trimWe,
  input  logic [SEL_W-1:0]  trimVal,
  output logic [SEL_W-1:0]  tapSel,
  input  logic [PW-1:0]     cfgTarget,
  input  logic [PW-1:0]     cfgMargin,
  input  logic [PW-1:0]     cfgHyst,
  input  logic [CODE_W-1:0] cfgMinCode,
  input  logic [CODE_W-1:0] cfgMaxCode,
  input  logic [TAPS-1:0]   tapVec,
  output logic              vUp,
  output logic [CODE_W-1:0] vCode,
  output logic [PW-1:0]     edgePos,
  output logic              bubbleErr
);
  logic [TAPS-1:0] capReg;
  logic [PW-1:0]   rawPos;
  logic            wordOk;
  logic            trimLocked;
  logic [STW-1:0]  settleCnt;
  logic [XW-1:0]   thrLo, thrHi, posX;
  logic            wantUp, wantDown;

  tapDecode #(.N(TAPS), .PW(PW)) uDec (
    .word (capReg),
    .pos  (rawPos),
    .valid(wordOk)
  );

  assign thrLo = XW'(cfgTarget) + XW'(cfgMargin);
  assign thrHi = thrLo + XW'(cfgHyst);
  assign posX  = XW'(rawPos);

  assign wantUp   = wordOk && (posX < thrLo) && (vCode < cfgMaxCode);
  assign wantDown = wordOk && (posX > thrHi) && (vCode > cfgMinCode);

  assign flags.wantUp     = strobe.eval && wantUp;
  assign flags.wantDown   = strobe.eval && wantDown;
  assign flags.settleDone = (settleCnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tapSel     <= '0;
      trimLocked <= 1'b0;
    end else if (trimWe && !trimLocked) begin
      tapSel     <= trimVal;
      trimLocked <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capReg    <= '0;
      edgePos   <= '0;
      bubbleErr <= 1'b0;
      vUp       <= 1'b0;
    end else begin
      if (strobe.capture) capReg <= tapVec;
      if (strobe.eval) begin
        if (wordOk) edgePos   <= rawPos;
        else        bubbleErr <= 1'b1;
        vUp <= wantUp;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vCode     <= CODE_W'(CODE_INIT);
      settleCnt <= '0;
    end else if (strobe.step) begin
      vCode     <= vUp ? vCode + 1'b1 : vCode - 1'b1;
      settleCnt <= STW'(SETTLE_CYC - 1);
    end else if (settleCnt != '0) begin
      settleCnt <= settleCnt - 1'b1;
    end
  end
endmodule

// File: rtl/replicaServo.sv
module replicaServo
  import servoPkg::*;
#(
  parameter int TAPS       = 16,
  parameter int CODE_W     = 6,
  parameter int TRIM_STEPS = 8,
  parameter int SETTLE_CYC = 4,
  parameter int CODE_INIT  = 8,
  localparam int PW        = $clog2(TAPS + 1),
  localparam int SEL_W     = $clog2(TRIM_STEPS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              trimWe,
  input  logic [SEL_W-1:0]  trimVal,
  output logic [SEL_W-1:0]  tapSel,
  input  logic [PW-1:0]     cfgTarget,
  input  logic [PW-1:0]     cfgMargin,
  input  logic [PW-1:0]     cfgHyst,
  input  logic [CODE_W-1:0] cfgMinCode,
  input  logic [CODE_W-1:0] cfgMaxCode,
  output logic              launch,
  output logic              sample,
  input  logic [TAPS-1:0]   tapVec,
  output logic              vReq,
  output logic              vUp,
  input  logic              vAck,
  output logic [CODE_W-1:0] vCode,
  output logic [PW-1:0]     edgePos,
  output logic              bubbleErr
);
  servoStrobe_t strobe;
  servoFlags_t  flags;

  servoControl uCtl (
    .clk   (clk),
    .rstN  (rstN),
    .enable(enable),
    .vAck  (vAck),
    .flags (flags),
    .strobe(strobe),
    .launch(launch),
    .sample(sample),
    .vReq  (vReq)
  );

  servoDatapath #(
    .TAPS(TAPS), .CODE_W(CODE_W), .SEL_W(SEL_W),
    .SETTLE_CYC(SETTLE_CYC), .CODE_INIT(CODE_INIT)
  ) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .flags     (flags),
    .trimWe    (trimWe),
    .trimVal   (trimVal),
    .tapSel    (tapSel),
    .cfgTarget (cfgTarget),
    .cfgMargin (cfgMargin),
    .cfgHyst   (cfgHyst),
    .cfgMinCode(cfgMinCode),
    .cfgMaxCode(cfgMaxCode),
    .tapVec    (tapVec),
    .vUp       (vUp),
    .vCode     (vCode),
    .edgePos   (edgePos),
    .bubbleErr (bubbleErr)
  );
endmodule

// File: rtl/servoChecker.sv
module servoChecker #(
  parameter int CODE_W     = 6,
  parameter int SETTLE_CYC = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              launch,
  input logic              sample,
  input logic              vReq,
  input logic              vUp,
  input logic              vAck,
  input logic [CODE_W-1:0] vCode,
  input logic [CODE_W-1:0] cfgMinCode,
  input logic [CODE_W-1:0] cfgMaxCode,
  input logic              bubbleErr
);
  // Cycles since the last acknowledge, saturating at SETTLE_CYC
  logic [31:0] sinceAck;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                     sinceAck <= 32'(SETTLE_CYC);
    else if (vReq && vAck)         sinceAck <= '0;
    else if (sinceAck < 32'(SETTLE_CYC)) sinceAck <= sinceAck + 1'b1;
  end

  a_r1_launch_then_sample: assert property (@(posedge clk) disable iff (!rstN)
    launch |=> sample && !launch);

  a_r1_no_overlap: assert property (@(posedge clk) disable iff (!rstN)
    !(launch && sample));

  a_r3_bubble_sticky: assert property (@(posedge clk) disable iff (!rstN)
    bubbleErr |=> bubbleErr);

  a_r6_req_hold: assert property (@(posedge clk) disable iff (!rstN)
    vReq && !vAck |=> vReq && $stable(vUp));

  a_r6_code_only_on_ack: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(vCode) |-> $past(vReq && vAck));

  a_r6_step_up: assert property (@(posedge clk) disable iff (!rstN)
    vReq && vAck && vUp |=> vCode == CODE_W'($past(vCode) + 1'b1));

  a_r6_step_down: assert property (@(posedge clk) disable iff (!rstN)
    vReq && vAck && !vUp |=> vCode == CODE_W'($past(vCode) - 1'b1));

  a_r6_quiet_during_req: assert property (@(posedge clk) disable iff (!rstN)
    vReq |-> !launch && !sample);

  a_r7_settle: assert property (@(posedge clk) disable iff (!rstN)
    launch |-> sinceAck >= 32'(SETTLE_CYC));

  a_r8_limits: assert property (@(posedge clk) disable iff (!rstN)
    vReq |-> (vUp ? (vCode < cfgMaxCode) : (vCode > cfgMinCode)));
endmodule

bind replicaServo servoChecker #(.CODE_W(CODE_W), .SETTLE_CYC(SETTLE_CYC)) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .launch    (launch),
  .sample    (sample),
  .vReq      (vReq),
  .vUp       (vUp),
  .vAck      (vAck),
  .vCode     (vCode),
  .cfgMinCode(cfgMinCode),
  .cfgMaxCode(cfgMaxCode),
  .bubbleErr (bubbleErr)
);

// File: tb/sim_replicaServo.sv
module sim_replicaServo;
  localparam int N = 16, PW = 5, CW = 6, TRIM = 8, SW = 3, SETTLE = 4;
  localparam int TGT = 8, MRG = 2, HYS = 2, MINC = 4, MAXC = 10, INIT = 8;
  localparam int NITEMS = 14;

  logic clk = 0, rstN = 0, enable = 0, trimWe = 0, vAck = 0;
  logic [SW-1:0] trimVal = '0;
  logic [SW-1:0] tapSel;
  logic launch, sample, vReq, vUp, bubbleErr;
  logic [N-1:0] tapVec = '0;
  logic [CW-1:0] vCode;
  logic [PW-1:0] edgePos;

  replicaServo #(.TAPS(N), .CODE_W(CW), .TRIM_STEPS(TRIM),
                 .SETTLE_CYC(SETTLE), .CODE_INIT(INIT)) u0 (
    .clk(clk), .rstN(rstN), .enable(enable), .trimWe(trimWe), .trimVal(trimVal),
    .tapSel(tapSel), .cfgTarget(PW'(TGT)), .cfgMargin(PW'(MRG)), .cfgHyst(PW'(HYS)),
    .cfgMinCode(CW'(MINC)), .cfgMaxCode(CW'(MAXC)), .launch(launch), .sample(sample),
    .tapVec(tapVec), .vReq(vReq), .vUp(vUp), .vAck(vAck), .vCode(vCode),
    .edgePos(edgePos), .bubbleErr(bubbleErr));

  always #4 clk = ~clk;

  int nChecks = 0, nFails = 0;
  int cyc = 0, ackCyc = 0;
  bit done = 0;

  // kind: 0 hold, 1 raise, 2 lower, 3 bubble
  typedef struct { int kind; int code; int pos; } exp_t;
  exp_t sbq[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(string req, int act, int expv);
    nChecks++;
    if (act != expv) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // Regulator model: acknowledge one cycle after a request appears
  always @(negedge clk) begin
    if (vReq && !vAck) begin
      vAck = 1'b1;
      ackCyc = cyc;
    end else vAck = 1'b0;
  end

  // Driver: present a tap word at each launch and push the expected outcome
  task automatic driveItems();
    int posList[NITEMS] = '{3, 10, 12, 9, 0, -1, 13, 16, 16, 16, 16, 16, 16, 11};
    int code = INIT;
    int lastPos = 0;
    for (int i = 0; i < NITEMS; i++) begin
      exp_t e;
      int p = posList[i];
      do @(negedge clk); while (!launch);
      if (p < 0) tapVec = 16'h00F5;
      else tapVec = N'((33'h1 << p) - 1);
      if (p < 0) e.kind = 3;
      else if (p < TGT + MRG) e.kind = (code < MAXC) ? 1 : 0;
      else if (p > TGT + MRG + HYS) e.kind = (code > MINC) ? 2 : 0;
      else e.kind = 0;
      if (e.kind == 1) code++;
      if (e.kind == 2) code--;
      if (p >= 0) lastPos = p;
      e.code = code;
      e.pos = lastPos;
      sbq.push_back(e);
      @(negedge clk);
      chk("R1 sample after launch", int'(sample), 1);
      chk("R1 launch one cycle", int'(launch), 0);
    end
  endtask

  // Monitor: compare decisions, status and code against the scoreboard
  initial begin
    wait (rstN);
    for (int i = 0; i < NITEMS; i++) begin
      exp_t e;
      int gotKind, expKind;
      string tag;
      @(negedge clk);
      while (!sample) @(negedge clk);
      if (sbq.size() == 0) begin
        chk("R1 scoreboard empty", 0, 1);
        e = '{0, 0, 0};
      end else e = sbq.pop_front();
      tag = (e.kind == 3) ? "R3" : (e.kind == 1) ? "R4" : (e.kind == 2) ? "R5" : "R5/R8 hold";
      @(posedge clk); @(posedge clk); @(negedge clk);
      gotKind = vReq ? (vUp ? 1 : 2) : 0;
      expKind = (e.kind == 3) ? 0 : e.kind;
      chk({tag, " decision"}, gotKind, expKind);
      if (e.kind == 3) chk("R3 bubbleErr set", int'(bubbleErr), 1);
      chk("R2 edgePos", int'(edgePos), e.pos);
      while (!launch) @(negedge clk);
      chk("R6/R8 vCode", int'(vCode), e.code);
      if (e.kind == 1 || e.kind == 2)
        chk("R7 settle spacing", cyc - ackCyc, SETTLE + 1);
    end
    done = 1;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R10 vCode", int'(vCode), INIT);
    chk("R10 vReq", int'(vReq), 0);
    chk("R10 launch", int'(launch), 0);
    chk("R10 sample", int'(sample), 0);
    chk("R10 bubbleErr", int'(bubbleErr), 0);
    chk("R10 edgePos", int'(edgePos), 0);
    rstN = 1;
    @(negedge clk);
    trimWe = 1; trimVal = 3'd5;
    @(negedge clk);
    trimWe = 0;
    chk("R9 first trim write", int'(tapSel), 5);
    trimWe = 1; trimVal = 3'd2;
    @(negedge clk);
    trimWe = 0;
    chk("R9 second trim ignored", int'(tapSel), 5);
    enable = 1;
    driveItems();
    wait (done);
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end
endmodule